// File: doc/BRIEF.md
# FIFO Loopback Self-Test Engine

This engine sits between the 32-byte receive FIFO and the 256-byte transmit buffer of a serial target. It gives the host a way to prove that both storage paths hold data correctly. First the host writes a key, then a go bit. After a settling interval it pushes 32 bytes into the receive FIFO. The engine then writes eight copies of those bytes into the transmit buffer, rotating every byte of copy k left by k bit positions, at one byte per clock. A single ready flag tells the host when it may push and when it may pull.

The host then drains the 256 bytes in any number of bursts, for example two bursts of 128 with a pause between them. It compares the bytes against the pattern it expects. A clear command ends the test from any phase and returns the engine to idle. Two sticky flags catch misuse: one for pulls that find no data, and one for pushes that find no room.

Top module: `fifo_loop_selftest`

## Requirements
- R1: A go pulse starts a test only when the preceding accepted key write carried 0x0A. A go pulse without that key, or after a key write of any other value, changes nothing, and ready stays 1.
- R2: After an accepted go, ready is 0 for exactly SETTLE_CYCLES clock cycles (default 625, which is 2.5 us at 250 MHz) and then returns to 1.
- R3: During the fill phase ready stays 1 while the first 31 bytes are pushed. The clock edge that accepts the 32nd byte drives ready to 0.
- R4: The copy phase holds ready at 0 for exactly 256 cycles, one transmit byte per cycle. Ready then returns to 1.
- R5: Pull number n (0 to 255), counted from the start of readout and unaffected by pauses between pulls, returns the receive byte at index n mod 32 rotated left by n div 32 bit positions. tx_byte changes on the clock edge that samples tx_rd and holds otherwise.
- R6: A pull made outside the readout phase (ready 0 included), or after all 256 bytes have been pulled, returns 0x00 and sets underflow, which stays set until clear.
- R7: A push made outside the fill phase is dropped and sets overflow, which stays set until clear. The transmit data already stored is unchanged.
- R8: A clear pulse returns the engine to idle from any phase. It resets the fill, copy and read pointers, clears both sticky flags and drives ready to 1. A clear in the same cycle as any other command takes priority.
- R9: Each key write serves a single go. After a clear, a go without a fresh key write is ignored.
- R10: After reset, ready is 1, tx_byte is 0x00, and underflow and overflow are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| unlock_wr | input | 1 | Key register write strobe |
| unlock_val | input | 8 | Key value written |
| go_wr | input | 1 | Go bit write strobe |
| clr_wr | input | 1 | Clear command strobe |
| rx_wr | input | 1 | Receive FIFO push strobe |
| rx_byte | input | 8 | Byte pushed into the receive FIFO |
| tx_rd | input | 1 | Transmit buffer pull strobe |
| tx_byte | output | 8 | Byte pulled from the transmit buffer |
| ready | output | 1 | High when the host may push or pull |
| underflow | output | 1 | Sticky flag for an empty or early pull |
| overflow | output | 1 | Sticky flag for a push that was dropped |

## Verification
The hardest situation to reach is a clear that arrives in the middle of a phase and leaves stale pointers behind. The visible result would come only later, as bytes shifted by the wrong amount in the next test. The stimulus aborts a fill after ten bytes and a copy right after it starts. It then runs a full test and compares all 256 bytes, so any pointer the clear missed shows up as a data mismatch. The phase lengths are measured by counting the cycles in which ready is low, not by sampling at fixed offsets.

// File: rtl/fifo_loop_selftest.sv
module fifo_loop_selftest #(
  parameter int BYTE_W        = 8,
  parameter int RX_DEPTH      = 32,
  parameter int COPIES        = 8,
  parameter int SETTLE_CYCLES = 625,
  parameter logic [7:0] KEY   = 8'h0A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unlock_wr,
  input  logic [7:0]        unlock_val,
  input  logic              go_wr,
  input  logic              clr_wr,
  input  logic              rx_wr,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              tx_rd,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              ready,
  output logic              underflow,
  output logic              overflow
);
  localparam int IDX_W    = $clog2(RX_DEPTH);
  localparam int TX_DEPTH = RX_DEPTH * COPIES;
  localparam int TX_AW    = $clog2(TX_DEPTH);
  localparam int CNT_W    = $clog2(SETTLE_CYCLES + 1);

  typedef enum logic [2:0] {IDLE, UNLOCKED, GO_SETTLE, FILL, COPY, READOUT} state_t;
  state_t state;

  logic [BYTE_W-1:0] rx_mem [RX_DEPTH];
  logic [BYTE_W-1:0] tx_mem [TX_DEPTH];
  logic [IDX_W-1:0]  wr_ptr;
  logic [TX_AW-1:0]  cp_ptr;
  logic [TX_AW:0]    rd_ptr;
  logic [CNT_W-1:0]  settle;

  function automatic logic [BYTE_W-1:0] rotl(input logic [BYTE_W-1:0] b, input int unsigned k);
    logic [2*BYTE_W-1:0] t;
    t = {b, b} << (k % BYTE_W);
    return t[2*BYTE_W-1:BYTE_W];
  endfunction

  wire fill_wr  = rx_wr && state == FILL;
  wire rd_ok    = tx_rd && state == READOUT && rd_ptr != (TX_AW+1)'(TX_DEPTH);
  wire last_in  = wr_ptr == IDX_W'(RX_DEPTH - 1);
  wire last_cp  = cp_ptr == TX_AW'(TX_DEPTH - 1);
  assign ready  = state != GO_SETTLE && state != COPY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= IDLE;
      wr_ptr    <= '0;
      cp_ptr    <= '0;
      rd_ptr    <= '0;
      settle    <= '0;
      tx_byte   <= '0;
      underflow <= 1'b0;
      overflow  <= 1'b0;
    end else if (clr_wr) begin
      state     <= IDLE;
      wr_ptr    <= '0;
      cp_ptr    <= '0;
      rd_ptr    <= '0;
      settle    <= '0;
      underflow <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (rx_wr && state != FILL) overflow <= 1'b1;
      if (tx_rd) begin
        if (rd_ok) begin
          tx_byte <= tx_mem[rd_ptr[TX_AW-1:0]];
          rd_ptr  <= rd_ptr + 1'b1;
        end else begin
          tx_byte   <= '0;
          underflow <= 1'b1;
        end
      end
      unique case (state)
        IDLE:
          if (unlock_wr && unlock_val == KEY) state <= UNLOCKED;
        UNLOCKED:
          if (go_wr) begin
            state  <= GO_SETTLE;
            settle <= CNT_W'(SETTLE_CYCLES - 1);
          end else if (unlock_wr && unlock_val != KEY) begin
            state <= IDLE;
          end
        GO_SETTLE:
          if (settle == '0) state <= FILL;
          else settle <= settle - 1'b1;
        FILL:
          if (fill_wr) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (last_in) begin
              state  <= COPY;
              cp_ptr <= '0;
            end
          end
        COPY: begin
          cp_ptr <= cp_ptr + 1'b1;
          if (last_cp) begin
            state  <= READOUT;
            rd_ptr <= '0;
          end
        end
        READOUT: ;
        default: state <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (fill_wr && !clr_wr) rx_mem[wr_ptr] <= rx_byte;
    if (state == COPY && !clr_wr)
      tx_mem[cp_ptr] <= rotl(rx_mem[cp_ptr[IDX_W-1:0]], 32'(cp_ptr >> IDX_W));
  end
endmodule

module fifo_loop_selftest_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              go_wr,
  input logic              clr_wr,
  input logic              rx_wr,
  input logic              tx_rd,
  input logic [BYTE_W-1:0] tx_byte,
  input logic              ready,
  input logic              underflow,
  input logic              overflow
);
  AST_EARLY_PULL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rd && !ready && !clr_wr |=> tx_byte == '0 && underflow); // R6
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !clr_wr |=> overflow); // R7
  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underflow && !clr_wr |=> underflow); // R6
  AST_READY_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(go_wr) || $past(rx_wr)); // R2
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ready && !underflow && !overflow); // R8
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_rd |=> $stable(tx_byte)); // R5
endmodule

bind fifo_loop_selftest fifo_loop_selftest_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .go_wr(go_wr), .clr_wr(clr_wr), .rx_wr(rx_wr),
  .tx_rd(tx_rd), .tx_byte(tx_byte), .ready(ready), .underflow(underflow),
  .overflow(overflow)
);

// File: tb/fifo_loop_selftest_test.sv
`timescale 1ns/1ps
module fifo_loop_selftest_test;
  localparam int SETTLE = 625;
  localparam logic [15:0] VEC [4] = '{16'h0001, 16'h8011, 16'hA53C, 16'hFF00};

  logic clk = 1'b0, rst_n = 1'b0;
  logic unlock_wr = 0, go_wr = 0, clr_wr = 0, rx_wr = 0, tx_rd = 0;
  logic [7:0] unlock_val = 0, rx_byte = 0;
  logic [7:0] tx_byte;
  logic ready, underflow, overflow;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fifo_loop_selftest uut (
    .clk(clk), .rst_n(rst_n), .unlock_wr(unlock_wr), .unlock_val(unlock_val),
    .go_wr(go_wr), .clr_wr(clr_wr), .rx_wr(rx_wr), .rx_byte(rx_byte),
    .tx_rd(tx_rd), .tx_byte(tx_byte), .ready(ready), .underflow(underflow),
    .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rot(input logic [7:0] b, input int k);
    for (int i = 0; i < k; i++) b = {b[6:0], b[7]};
    return b;
  endfunction

  task automatic key(input logic [7:0] v);
    @(negedge clk) begin unlock_wr = 1; unlock_val = v; end
    @(negedge clk) unlock_wr = 0;
  endtask
  task automatic go();
    @(negedge clk) go_wr = 1;
    @(negedge clk) go_wr = 0;
  endtask
  task automatic clear();
    @(negedge clk) clr_wr = 1;
    @(negedge clk) clr_wr = 0;
  endtask
  task automatic push(input logic [7:0] b);
    @(negedge clk) begin rx_wr = 1; rx_byte = b; end
    @(negedge clk) rx_wr = 0;
  endtask
  task automatic pull(output logic [7:0] b);
    @(negedge clk) tx_rd = 1;
    @(negedge clk) tx_rd = 0;
    b = tx_byte;
  endtask
  task automatic count_low(output int n);
    n = 0;
    while (!ready && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic run_test(input logic [7:0] seed, input logic [7:0] step, input bit extra);
    logic [7:0] src [32];
    logic [7:0] b;
    int n, bad, hi;
    key(8'h0A);
    go();
    count_low(n);
    check(n == SETTLE, "R2 settle cycles", n, SETTLE);
    hi = 1;
    for (int i = 0; i < 32; i++) begin
      src[i] = seed + 8'(i) * step;
      push(src[i]);
      if (i < 31 && !ready) hi = 0;
    end
    check(hi == 1, "R3 ready high while filling", hi, 1);
    check(ready == 0, "R3 ready low after 32nd byte", ready, 0);
    count_low(n);
    check(n == 256, "R4 copy cycles", n, 256);
    if (extra) begin
      push(8'h5A);
      check(overflow == 1, "R7 push in readout flags overflow", overflow, 1);
    end
    for (int burst = 0; burst < 2; burst++) begin
      bad = 0;
      for (int j = 0; j < 128; j++) begin
        int idx;
        idx = burst * 128 + j;
        pull(b);
        if (b !== exp_rot(src[idx % 32], idx / 32)) begin
          if (bad == 0)
            $display("FAIL R5 byte %0d actual=%0h expected=%0h", idx, b, exp_rot(src[idx % 32], idx / 32));
          bad++;
        end
      end
      check(bad == 0, "R5 burst data", bad, 0);
      repeat (10) @(negedge clk);
    end
    check(underflow == 0, "R6 no underflow during valid reads", underflow, 0);
    pull(b);
    check(b == 0 && underflow == 1, "R6 pull past end", {b, 7'b0, underflow}, 1);
    clear();
    go();
    check(ready == 1, "R9 go after clear without key", ready, 1);
    push(8'h11);
    check(overflow == 1, "R9 engine not filling", overflow, 1);
    clear();
  endtask

  initial begin
    logic [7:0] b;
    int n;
    repeat (3) @(negedge clk);
    check(ready == 1 && tx_byte == 0 && !underflow && !overflow, "R10 reset state",
          {ready, tx_byte, underflow, overflow}, 11'h400);
    rst_n = 1;
    @(negedge clk);

    go();
    check(ready == 1, "R1 go without key ignored", ready, 1);
    push(8'h33);
    check(overflow == 1, "R7 push when idle flags overflow", overflow, 1);
    clear();
    check(ready == 1 && !overflow && !underflow, "R8 clear resets flags", {ready, overflow, underflow}, 4);

    key(8'h0B);
    go();
    check(ready == 1, "R1 wrong key ignored", ready, 1);
    pull(b);
    check(b == 0 && underflow == 1, "R6 pull while idle", {b, 7'b0, underflow}, 1);
    clear();

    key(8'h0A);
    go();
    pull(b);
    check(b == 0 && underflow == 1, "R6 pull while ready low", {b, 7'b0, underflow}, 1);
    clear();

    for (int v = 0; v < 4; v++) begin
      if (v == 3) begin
        key(8'h0A);
        go();
        count_low(n);
        for (int i = 0; i < 10; i++) push(8'hE0 + 8'(i));
        clear();
        check(ready == 1, "R8 clear during fill", ready, 1);
        key(8'h0A);
        go();
        count_low(n);
        for (int i = 0; i < 32; i++) push(8'hC3);
        check(ready == 0, "R4 copy started", ready, 0);
        clear();
        check(ready == 1, "R8 clear during copy", ready, 1);
      end
      run_test(VEC[v][15:8], VEC[v][7:0], v == 1);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule